// File: doc/BRIEF.md
# Multi-rate retry transmit controller

This block runs the transmission attempts for a single frame across an ordered set of rate stages. A descriptor carries, for each stage, a rate code and a try budget. Once the descriptor is taken, the controller issues attempt requests and waits after each one for an acknowledge or an acknowledge timeout. A timeout triggers a retry at the same rate while that stage still has budget. When the budget is used up, the controller moves to the next stage. Software plays no part in this sequence. When the frame ends, the controller reports success or failure, the stage it finished on and the total number of attempts.

The descriptor input, the attempt request and the completion report are valid/ready streams. A transfer happens on any rising clock edge where both valid and ready are high.

- Descriptor: `desc_ready` is high only while the controller is idle. A descriptor offered while the controller is busy waits until the controller returns to idle.
- Attempt request: `att_valid` stays high, with rate and stage stable, until the transmitter raises `att_ready`.
- Completion report: `done_valid` and its fields stay high and stable until `done_ready` is seen.

The acknowledge and timeout inputs are plain one-cycle pulses. They come from the transmitter and its timer.

Top module: `mrr_tx_ctrl`

## Requirements
- R1: `desc_ready` is high exactly when the controller is idle, and a descriptor is taken only on a cycle with `desc_valid` and `desc_ready` both high. `busy` is high from the edge that takes a descriptor until the edge that completes the completion handshake. Descriptor fields changed while busy have no effect on the frame in flight.
- R2: Stage i of the descriptor holds its rate in `desc_rates[i*RW +: RW]` and its try count in `desc_tries[i*TW +: TW]`. The first attempt uses the lowest-index stage whose try count is non-zero: `att_stage` is that index and `att_rate` is that stage's rate.
- R3: While `att_valid` is high and `att_ready` is low, `att_valid` stays high and `att_rate` and `att_stage` keep their values.
- R4: An `ack_ok` pulse after an accepted attempt ends the frame with `done_success`=1. `done_stage` is the current stage and `done_attempts` is the number of accepted attempts. `ack_ok` wins over an `ack_timeout` in the same cycle.
- R5: An `ack_timeout` pulse after an accepted attempt, while the current stage has used fewer timeouts than its try count, leads to a new request on the same stage.
- R6: When a stage's try count is used up, the next request uses the next higher-index stage with a non-zero try count. Stages with a try count of zero are never requested, and the stage index never decreases within a frame.
- R7: When the last stage with budget is used up without an acknowledge, the frame ends with `done_success`=0. `done_stage` is the last stage tried and `done_attempts` is the sum of all try counts.
- R8: A descriptor whose try counts are all zero ends at once with `done_success`=0, `done_stage`=NSTG-1 and `done_attempts`=0, and no request is issued.
- R9: While `done_valid` is high and `done_ready` is low, `done_valid` stays high and all completion fields keep their values.
- R10: `ack_ok` and `ack_timeout` have no effect unless an accepted attempt is awaiting its outcome. This covers the idle state, a pending request and a pending completion report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Controller idle, descriptor can be taken |
| desc_rates | input | NSTG*RW | Rate code per stage, stage i at bits i*RW |
| desc_tries | input | NSTG*TW | Try budget per stage, stage i at bits i*TW |
| busy | output | 1 | Frame in progress |
| att_valid | output | 1 | Attempt request pending |
| att_ready | input | 1 | Transmitter takes the request |
| att_rate | output | RW | Rate code for the requested attempt |
| att_stage | output | SW | Stage index of the requested attempt |
| ack_ok | input | 1 | Acknowledge received for the last attempt |
| ack_timeout | input | 1 | Acknowledge timer expired for the last attempt |
| done_valid | output | 1 | Completion report pending |
| done_ready | input | 1 | Completion report taken |
| done_success | output | 1 | 1 when the frame was acknowledged |
| done_stage | output | SW | Stage that succeeded or last failed |
| done_attempts | output | AW | Total accepted attempts for the frame |

## Verification
A wrong stage pointer or try counter shows on `att_stage` and `att_rate` at the very next request after a timeout. That request can be one cycle after the timeout pulse. A skipped or extra attempt also changes `done_attempts` when the frame closes. A state machine that responds to stray acknowledge pulses, or that takes a second descriptor, ends a frame early or changes its rates. This shows within a cycle as an early `done_valid` or a changed request, or as a mismatch when the frame completes.

// File: rtl/mrr_pkg.sv
package mrr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } mrr_state_e;
endpackage

// File: rtl/mrr_stage_pick.sv
// Lowest-index stage that is allowed and has a non-zero try budget.
module mrr_stage_pick #(
  parameter int NSTG = 4,
  parameter int TW   = 4,
  localparam int SW  = (NSTG > 1) ? $clog2(NSTG) : 1
) (
  input  logic [NSTG*TW-1:0] tries,
  input  logic [NSTG-1:0]    allow,
  output logic               found,
  output logic [SW-1:0]      idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NSTG - 1; i >= 0; i--) begin
      if (allow[i] && (tries[i*TW +: TW] != '0)) begin
        found = 1'b1;
        idx   = SW'(i);
      end
    end
  end
endmodule

// File: rtl/mrr_tally.sv
// Per-stage timeout count and per-frame attempt total.
module mrr_tally #(
  parameter int NSTG = 4,
  parameter int TW   = 4,
  localparam int MAXA = NSTG * ((1 << TW) - 1),
  localparam int AW   = $clog2(MAXA + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_all,
  input  logic          add_att,
  input  logic          add_fail,
  input  logic          next_stage,
  output logic [TW-1:0] used,
  output logic [AW-1:0] total
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used  <= '0;
      total <= '0;
    end else begin
      if (clr_all || next_stage) used <= '0;
      else if (add_fail)         used <= used + 1'b1;
      if (clr_all)               total <= '0;
      else if (add_att)          total <= total + 1'b1;
    end
  end

  p_total_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(total) <= MAXA);
endmodule

// File: rtl/mrr_tx_ctrl.sv
module mrr_tx_ctrl
  import mrr_pkg::*;
#(
  parameter int NSTG = 4,
  parameter int RW   = 4,
  parameter int TW   = 4,
  localparam int SW   = (NSTG > 1) ? $clog2(NSTG) : 1,
  localparam int MAXA = NSTG * ((1 << TW) - 1),
  localparam int AW   = $clog2(MAXA + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               desc_valid,
  output logic               desc_ready,
  input  logic [NSTG*RW-1:0] desc_rates,
  input  logic [NSTG*TW-1:0] desc_tries,
  output logic               busy,
  output logic               att_valid,
  input  logic               att_ready,
  output logic [RW-1:0]      att_rate,
  output logic [SW-1:0]      att_stage,
  input  logic               ack_ok,
  input  logic               ack_timeout,
  output logic               done_valid,
  input  logic               done_ready,
  output logic               done_success,
  output logic [SW-1:0]      done_stage,
  output logic [AW-1:0]      done_attempts
);
  mrr_state_e          state;
  logic [NSTG*RW-1:0]  rates_q;
  logic [NSTG*TW-1:0]  tries_q;
  logic [SW-1:0]       cur_q;
  logic                ok_q;

  logic                fire_desc, fire_att, in_wait, got_ok, got_to, last_try;
  logic                found_f, found_n;
  logic [SW-1:0]       idx_f, idx_n;
  logic [NSTG-1:0]     allow_all, allow_up;
  logic [TW-1:0]       used, cur_tries;
  logic [TW:0]         used_nx;
  logic [AW-1:0]       total;

  assign fire_desc = desc_valid && (state == ST_IDLE);
  assign fire_att  = att_valid && att_ready;
  assign in_wait   = (state == ST_WAIT);
  assign got_ok    = in_wait && ack_ok;
  assign got_to    = in_wait && !ack_ok && ack_timeout;
  assign cur_tries = tries_q[cur_q*TW +: TW];
  assign used_nx   = {1'b0, used} + (TW+1)'(1);
  assign last_try  = (used_nx == {1'b0, cur_tries});

  assign allow_all = '1;
  for (genvar g = 0; g < NSTG; g++) begin : g_allow
    assign allow_up[g] = (g > int'(cur_q));
  end

  mrr_stage_pick #(.NSTG(NSTG), .TW(TW)) u_pick_first (
    .tries(desc_tries), .allow(allow_all), .found(found_f), .idx(idx_f));

  mrr_stage_pick #(.NSTG(NSTG), .TW(TW)) u_pick_next (
    .tries(tries_q), .allow(allow_up), .found(found_n), .idx(idx_n));

  mrr_tally #(.NSTG(NSTG), .TW(TW)) u_tally (
    .clk(clk), .rst_n(rst_n), .clr_all(fire_desc), .add_att(fire_att),
    .add_fail(got_to), .next_stage(got_to && last_try),
    .used(used), .total(total));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      rates_q <= '0;
      tries_q <= '0;
      cur_q   <= '0;
      ok_q    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (fire_desc) begin
          rates_q <= desc_rates;
          tries_q <= desc_tries;
          ok_q    <= 1'b0;
          if (found_f) begin
            cur_q <= idx_f;
            state <= ST_REQ;
          end else begin
            cur_q <= SW'(NSTG - 1);
            state <= ST_DONE;
          end
        end
        ST_REQ: if (att_ready) state <= ST_WAIT;
        ST_WAIT: begin
          if (got_ok) begin
            ok_q  <= 1'b1;
            state <= ST_DONE;
          end else if (got_to) begin
            if (!last_try) begin
              state <= ST_REQ;
            end else if (found_n) begin
              cur_q <= idx_n;
              state <= ST_REQ;
            end else begin
              state <= ST_DONE;
            end
          end
        end
        ST_DONE: if (done_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign desc_ready    = (state == ST_IDLE);
  assign busy          = (state != ST_IDLE);
  assign att_valid     = (state == ST_REQ);
  assign att_rate      = rates_q[cur_q*RW +: RW];
  assign att_stage     = cur_q;
  assign done_valid    = (state == ST_DONE);
  assign done_success  = ok_q;
  assign done_stage    = cur_q;
  assign done_attempts = total;

  p_accept_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && desc_ready |=> busy && !desc_ready);
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    att_valid && !att_ready |=> att_valid && $stable(att_rate) && $stable(att_stage));
  p_stage_fwd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> cur_q >= $past(cur_q));
  p_no_zero_stage_r6: assert property (@(posedge clk) disable iff (!rst_n)
    att_valid |-> tries_q[att_stage*TW +: TW] != '0);
  p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && !done_ready |=> done_valid &&
      $stable({done_success, done_stage, done_attempts}));
  p_stray_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && !done_ready |=> $stable(done_success));
endmodule

// File: tb/mrr_tx_ctrl_bench.sv
`timescale 1ns/1ps
module mrr_tx_ctrl_bench;
  localparam int NSTG = 4;
  localparam int RW   = 4;
  localparam int TW   = 4;
  localparam int SW   = 2;
  localparam int AW   = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic desc_valid = 1'b0, att_ready = 1'b0, ack_ok = 1'b0, ack_timeout = 1'b0;
  logic done_ready = 1'b0;
  logic [NSTG*RW-1:0] desc_rates = '0;
  logic [NSTG*TW-1:0] desc_tries = '0;
  logic desc_ready, busy, att_valid, done_valid, done_success;
  logic [RW-1:0] att_rate;
  logic [SW-1:0] att_stage, done_stage;
  logic [AW-1:0] done_attempts;

  int n_chk = 0, n_bad = 0;
  int rates[NSTG];
  int tries[NSTG];

  always #2.5 clk = ~clk;

  mrr_tx_ctrl #(.NSTG(NSTG), .RW(RW), .TW(TW)) u_mrr_tx_ctrl (
    .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_rates(desc_rates), .desc_tries(desc_tries), .busy(busy),
    .att_valid(att_valid), .att_ready(att_ready), .att_rate(att_rate),
    .att_stage(att_stage), .ack_ok(ack_ok), .ack_timeout(ack_timeout),
    .done_valid(done_valid), .done_ready(done_ready), .done_success(done_success),
    .done_stage(done_stage), .done_attempts(done_attempts));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int nxt(input int from);
    for (int s = from; s < NSTG; s++) if (tries[s] != 0) return s;
    return NSTG;
  endfunction

  task automatic run_frame(input int ack_at);
    int es, eu, n, last, k, e_ok, e_stg, e_n, r0, r1, r2;
    bit fin;
    for (int s = 0; s < NSTG; s++) begin
      desc_rates[s*RW +: RW] = RW'(rates[s]);
      desc_tries[s*TW +: TW] = TW'(tries[s]);
    end
    chk("R1 ready when idle", int'(desc_ready), 1);
    desc_valid = 1'b1;
    @(negedge clk);
    chk("R1 busy after accept", int'(busy), 1);
    chk("R1 not ready when busy", int'(desc_ready), 0);
    desc_rates = ~desc_rates;
    desc_tries = '1;
    es = nxt(0); eu = 0; n = 0; last = 0; fin = 0;
    e_ok = 0; e_stg = NSTG - 1; e_n = 0;
    if (es == NSTG) fin = 1;
    while (!fin) begin
      while (!att_valid && !done_valid) @(negedge clk);
      if (done_valid) begin
        chk("R7 early completion", 1, 0);
        break;
      end
      chk(n == 0 ? "R2 first stage" : (eu == 0 ? "R6 next stage" : "R5 retry stage"),
          int'(att_stage), es);
      chk("R2 stage rate", int'(att_rate), rates[es]);
      k = $urandom_range(0, 2);
      r0 = int'(att_rate); r1 = int'(att_stage);
      repeat (k) begin
        ack_ok = 1'($urandom_range(0, 1));
        ack_timeout = 1'($urandom_range(0, 1));
        @(negedge clk);
        ack_ok = 1'b0; ack_timeout = 1'b0;
        chk("R10 R3 request held", int'(att_valid), 1);
        chk("R3 rate held", int'(att_rate), r0);
        chk("R3 stage held", int'(att_stage), r1);
      end
      att_ready = 1'b1;
      @(negedge clk);
      att_ready = 1'b0;
      n++;
      repeat ($urandom_range(0, 2)) @(negedge clk);
      if (n == ack_at) begin
        ack_ok = 1'b1;
        ack_timeout = 1'($urandom_range(0, 1));
        @(negedge clk);
        ack_ok = 1'b0; ack_timeout = 1'b0;
        e_ok = 1; e_stg = es; e_n = n; fin = 1;
      end else begin
        ack_timeout = 1'b1;
        @(negedge clk);
        ack_timeout = 1'b0;
        eu++;
        if (eu == tries[es]) begin
          last = es; es = nxt(es + 1); eu = 0;
          if (es == NSTG) begin
            e_ok = 0; e_stg = last; e_n = n; fin = 1;
          end
        end
      end
    end
    while (!done_valid) @(negedge clk);
    desc_valid = 1'b0;
    chk(e_ok ? "R4 success flag" : (e_n == 0 ? "R8 zero-budget flag" : "R7 failure flag"),
        int'(done_success), e_ok);
    chk(e_ok ? "R4 done stage" : (e_n == 0 ? "R8 zero-budget stage" : "R7 done stage"),
        int'(done_stage), e_stg);
    chk(e_ok ? "R4 attempt count" : (e_n == 0 ? "R8 zero attempts" : "R7 attempt count"),
        int'(done_attempts), e_n);
    r0 = int'(done_success); r1 = int'(done_stage); r2 = int'(done_attempts);
    repeat ($urandom_range(1, 3)) begin
      ack_ok = 1'($urandom_range(0, 1));
      ack_timeout = 1'b1;
      @(negedge clk);
      ack_ok = 1'b0; ack_timeout = 1'b0;
      chk("R9 done held", int'(done_valid), 1);
      chk("R9 R10 flag held", int'(done_success), r0);
      chk("R9 stage held", int'(done_stage), r1);
      chk("R9 attempts held", int'(done_attempts), r2);
    end
    done_ready = 1'b1;
    @(negedge clk);
    done_ready = 1'b0;
    chk("R1 idle after report", int'(desc_ready), 1);
    chk("R1 busy low after report", int'(busy), 0);
    chk("R9 done dropped", int'(done_valid), 0);
  endtask

  task automatic set_frame(input int t0, input int t1, input int t2, input int t3);
    tries[0] = t0; tries[1] = t1; tries[2] = t2; tries[3] = t3;
    for (int s = 0; s < NSTG; s++) rates[s] = $urandom_range(0, (1 << RW) - 1);
  endtask

  initial begin
    int tot;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset ready", int'(desc_ready), 1);
    chk("R1 reset busy", int'(busy), 0);
    chk("R2 reset no request", int'(att_valid), 0);
    chk("R9 reset no report", int'(done_valid), 0);
    ack_ok = 1'b1; ack_timeout = 1'b1;
    @(negedge clk);
    ack_ok = 1'b0; ack_timeout = 1'b0;
    @(negedge clk);
    chk("R10 idle ack ignored", int'(done_valid), 0);
    chk("R10 idle ack no request", int'(att_valid), 0);
    chk("R10 idle stays ready", int'(desc_ready), 1);

    set_frame(2, 1, 1, 1); run_frame(1);
    set_frame(0, 0, 0, 0); run_frame(0);
    set_frame(0, 2, 0, 1); run_frame(0);
    set_frame(3, 2, 1, 0); run_frame(0);
    set_frame(0, 0, 0, 1); run_frame(1);
    set_frame(15, 15, 15, 15); run_frame(0);
    set_frame(1, 1, 1, 1); run_frame(4);
    set_frame(2, 0, 3, 0); run_frame(4);

    for (int f = 0; f < 60; f++) begin
      set_frame($urandom_range(0, 3), $urandom_range(0, 3),
                $urandom_range(0, 3), $urandom_range(0, 3));
      tot = tries[0] + tries[1] + tries[2] + tries[3];
      run_frame(tot == 0 ? 0 : $urandom_range(0, tot));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule